// File: doc/BRIEF.md
# Branch-aware burst instruction fetcher

This block is the fetch stage of a short in-order pipeline that has no branch delay slot. It reads 32-bit instruction words over a Wishbone-style master port. Sequential addresses go out as incrementing linear bursts whose length is set by a parameter. Every word that comes back is pre-decoded in the same cycle as its acknowledge. A direct jump or a flag-conditional branch therefore ends the burst at once, and the fetcher restarts at the target it has computed itself. A register-indirect jump leaves the fetcher idle until execute supplies the target through the flush port.

An unconditional jump whose offset is zero (a jump to itself) puts the fetcher to sleep, and it issues no bus cycles while asleep. A timer tick wakes it at the tick vector. An interrupt-controller request wakes it at the external-interrupt vector, and the tick wins when both arrive together. Towards decode the block presents a registered instruction, the instruction's PC and a valid flag. It honours a stall input from the pipeline and a flush/redirect input.

Instruction encoding: the opcode is in bits [31:26], and bits [25:0] hold a signed word offset that is added to the instruction's own PC. The opcodes are:
- 6'h00: jump. An offset of 0 means sleep.
- 6'h03: branch if flag_i is 1.
- 6'h04: branch if flag_i is 0.
- 6'h11: jump to register.
- 6'h12: jump and link to register.

Every other opcode is a plain instruction.

Top module: `burst_fetch`

## Requirements
- R1: While rst_ni is low, wb_cyc_o and insn_valid_o are 0. After reset is released there is one idle cycle, and then fetching starts at RESET_VEC (default 32'h0000_0100).
- R2: Plain instructions are fetched in linear bursts, and each beat's address is 4 above the previous one. Every beat carries wb_bte_o=2'b00. Beat k of a transaction (counting from 0) carries wb_cti_o=3'b111 if k=BURST_LEN-1 and 3'b010 otherwise. Each acknowledged word appears on insn_o/pc_o with insn_valid_o=1 in the following cycle.
- R3: When an acknowledged word has opcode 6'h00, 6'h03, 6'h04, 6'h11 or 6'h12, no further beat follows it: wb_cyc_o is 0 in the next cycle.
- R4: When a transaction ends for any reason (last beat, branch, flush, wake), wb_cyc_o and wb_stb_o are low for exactly one cycle before the next transaction starts. The only exception is when the fetcher goes to sleep or waits for a register target.
- R5: The next transaction after a jump (6'h00, nonzero offset) starts at pc+4*offset. After 6'h03 or 6'h04 it starts at pc+4*offset if the branch is taken according to flag_i sampled at the acknowledge, and at pc+4 if it is not.
- R6: After 6'h11 or 6'h12 the fetcher makes no bus request until flush_i is asserted.
- R7: After a jump with zero offset the fetcher makes no bus request until a wake event or a flush.
- R8: While asleep, tick_irq_i restarts fetching at TICK_VEC (32'h500) and ext_irq_i restarts it at EXT_VEC (32'h800); tick wins. These inputs have no effect while the fetcher is awake.
- R9: While stall_i is 1, wb_stb_o is 0 and insn_o, pc_o and insn_valid_o hold their values.
- R10: flush_i discards any word acknowledged in the same cycle and clears insn_valid_o in the next cycle. After a one-cycle gap, fetching restarts at flush_pc_i.
- R11: There is no delay slot. The words delivered follow program order exactly, and no word after a branch is delivered unless it is the next instruction that the branch's outcome selects.
- R12: A branch on the final beat of a burst is redirected correctly, and no fetch is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Pipeline stall |
| flush_i | input | 1 | Redirect request |
| flush_pc_i | input | 32 | Redirect address |
| flag_i | input | 1 | Branch condition flag |
| tick_irq_i | input | 1 | Timer tick wake request |
| ext_irq_i | input | 1 | Interrupt-controller wake request |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_cti_o | output | 3 | Cycle type: 010 incrementing, 111 last |
| wb_bte_o | output | 2 | Burst type: 00 linear |
| wb_adr_o | output | 32 | Byte address |
| wb_ack_i | input | 1 | Bus acknowledge |
| wb_dat_i | input | 32 | Read data |
| insn_o | output | 32 | Instruction to decode |
| pc_o | output | 32 | PC of insn_o |
| insn_valid_o | output | 1 | insn_o is valid |

## Verification
A looping program mixes straight-line runs, which show that bursts stream and that the beat types are correct. It also contains forward and backward jumps, and conditional branches under a randomly changing flag, which separate the taken and not-taken targets. Random acknowledge wait states and stalls move branches to different beat positions, so the final-beat case is exercised and separated from the mid-burst case. A register jump, sleep instructions with tick, external and simultaneous wakes, stray interrupts while awake, and random flushes each show that the restart address and the one-cycle gap are correct.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_BUS   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SLEEP = 2'd3
  } fetch_state_e;

  localparam logic [5:0] OP_JUMP = 6'h00;
  localparam logic [5:0] OP_BF   = 6'h03;
  localparam logic [5:0] OP_BNF  = 6'h04;
  localparam logic [5:0] OP_JR   = 6'h11;
  localparam logic [5:0] OP_JALR = 6'h12;

  localparam logic [2:0] CTI_INCR = 3'b010;
  localparam logic [2:0] CTI_END  = 3'b111;
  localparam logic [1:0] BTE_LIN  = 2'b00;
endpackage

// File: rtl/fetch_predecode.sv
module fetch_predecode
  import fetch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [31:0]   insn_i,
  input  logic [AW-1:0] pc_i,
  input  logic          flag_i,
  output logic          ends_i_o,
  output logic          sleep_o,
  output logic          indirect_o,
  output logic [AW-1:0] next_pc_o
);
  logic [5:0]    op;
  logic [AW-1:0] disp;
  logic          taken;

  assign op   = insn_i[31:26];
  assign disp = AW'({{(AW-28){insn_i[25]}}, insn_i[25:0], 2'b00});

  always_comb begin
    taken      = 1'b0;
    ends_i_o   = 1'b0;
    sleep_o    = 1'b0;
    indirect_o = 1'b0;
    unique case (op)
      OP_JUMP: begin
        ends_i_o = 1'b1;
        taken    = 1'b1;
        sleep_o  = (insn_i[25:0] == 26'd0);
      end
      OP_BF: begin
        ends_i_o = 1'b1;
        taken    = flag_i;
      end
      OP_BNF: begin
        ends_i_o = 1'b1;
        taken    = ~flag_i;
      end
      OP_JR, OP_JALR: begin
        ends_i_o   = 1'b1;
        indirect_o = 1'b1;
      end
      default: ;
    endcase
    next_pc_o = taken ? pc_i + disp : pc_i + AW'(4);
  end
endmodule

// File: rtl/fetch_beat_ctr.sv
module fetch_beat_ctr #(
  parameter int BURST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(BURST_LEN - 1);

  logic [CW-1:0] cnt_q;

  generate
    if (BURST_LEN == 1) begin : g_single
      assign last_o = 1'b1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= '0;
      end
    end else begin : g_multi
      assign last_o = (cnt_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (clear_i)           cnt_q <= '0;
        else if (step_i && !last_o) cnt_q <= cnt_q + 1'b1;
      end

      assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/burst_fetch.sv
module burst_fetch
  import fetch_pkg::*;
#(
  parameter int          BURST_LEN = 4,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100,
  parameter logic [31:0] TICK_VEC  = 32'h0000_0500,
  parameter logic [31:0] EXT_VEC   = 32'h0000_0800
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stall_i,
  input  logic        flush_i,
  input  logic [31:0] flush_pc_i,
  input  logic        flag_i,
  input  logic        tick_irq_i,
  input  logic        ext_irq_i,
  output logic        wb_cyc_o,
  output logic        wb_stb_o,
  output logic [2:0]  wb_cti_o,
  output logic [1:0]  wb_bte_o,
  output logic [31:0] wb_adr_o,
  input  logic        wb_ack_i,
  input  logic [31:0] wb_dat_i,
  output logic [31:0] insn_o,
  output logic [31:0] pc_o,
  output logic        insn_valid_o
);
  fetch_state_e state_q, state_d;
  logic [31:0]  pc_q, pc_d;
  logic         beat_done, last_beat;
  logic         pd_ends, pd_sleep, pd_ind;
  logic [31:0]  pd_next;

  assign wb_cyc_o  = (state_q == ST_BUS);
  assign wb_stb_o  = wb_cyc_o & ~stall_i;
  assign wb_adr_o  = pc_q;
  assign wb_bte_o  = BTE_LIN;
  assign wb_cti_o  = last_beat ? CTI_END : CTI_INCR;
  assign beat_done = wb_stb_o & wb_ack_i & ~flush_i;

  fetch_predecode #(.AW(32)) u_pd (
    .insn_i    (wb_dat_i),
    .pc_i      (pc_q),
    .flag_i    (flag_i),
    .ends_i_o  (pd_ends),
    .sleep_o   (pd_sleep),
    .indirect_o(pd_ind),
    .next_pc_o (pd_next)
  );

  fetch_beat_ctr #(.BURST_LEN(BURST_LEN)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q != ST_BUS),
    .step_i (beat_done),
    .last_o (last_beat)
  );

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    if (flush_i) begin
      state_d = ST_GAP;
      pc_d    = flush_pc_i;
    end else begin
      unique case (state_q)
        ST_GAP: state_d = ST_BUS;
        ST_BUS: if (beat_done) begin
          pc_d = pd_next;
          if (pd_sleep)                   state_d = ST_SLEEP;
          else if (pd_ind)                state_d = ST_WAIT;
          else if (pd_ends || last_beat)  state_d = ST_GAP;
        end
        ST_SLEEP: begin
          if (tick_irq_i) begin
            state_d = ST_GAP;
            pc_d    = TICK_VEC;
          end else if (ext_irq_i) begin
            state_d = ST_GAP;
            pc_d    = EXT_VEC;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_GAP;
      pc_q    <= RESET_VEC;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insn_valid_o <= 1'b0;
      insn_o       <= '0;
      pc_o         <= '0;
    end else if (flush_i) begin
      insn_valid_o <= 1'b0;
    end else if (beat_done) begin
      insn_valid_o <= 1'b1;
      insn_o       <= wb_dat_i;
      pc_o         <= pc_q;
    end else if (!stall_i) begin
      insn_valid_o <= 1'b0;
    end
  end

  assert_branch_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_done && pd_ends) |=> !wb_cyc_o);
  assert_end_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_done && wb_cti_o == CTI_END) |=> !wb_cyc_o);
  assert_sleep_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && !tick_irq_i && !ext_irq_i && !flush_i) |=> (state_q == ST_SLEEP && !wb_cyc_o));
  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i) |=> ($stable(insn_o) && $stable(pc_o) && $stable(insn_valid_o)));
  assert_flush_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!insn_valid_o && !wb_cyc_o));
endmodule

// File: tb/burst_fetch_tb.sv
module burst_fetch_tb_top;
  localparam int BL = 4;
  localparam logic [31:0] RV = 32'h100, TV = 32'h500, EV = 32'h800, FV = 32'h140;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stall = 0, flush = 0, flag = 0, tick = 0, ext = 0, ack = 0;
  logic [31:0] fpc = '0, dat = '0;
  logic cyc, stb, valid;
  logic [2:0] cti;
  logic [1:0] bte;
  logic [31:0] adr, insn, pc;

  always #10 clk = ~clk;

  burst_fetch #(.BURST_LEN(BL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .flush_i(flush), .flush_pc_i(fpc),
    .flag_i(flag), .tick_irq_i(tick), .ext_irq_i(ext),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_cti_o(cti), .wb_bte_o(bte), .wb_adr_o(adr),
    .wb_ack_i(ack), .wb_dat_i(dat), .insn_o(insn), .pc_o(pc), .insn_valid_o(valid)
  );

  int checks = 0, fails = 0;
  int m_st = 0;            // 0 gap, 1 bus, 2 wait, 3 sleep
  int m_beat = 0, idle = 0, sleeps = 0, lastbr = 0, delivered = 0, stuck = 0;
  logic [31:0] m_pc = RV, e_insn = '0, e_pc = '0;
  logic e_valid = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] mk(logic [5:0] op, int off);
    logic [31:0] o = off;
    return {op, o[25:0]};
  endfunction

  function automatic logic [31:0] prog(logic [31:0] a);
    case (a)
      32'h128: return mk(6'h00, 16);
      32'h16c: return mk(6'h03, 8);
      32'h18c: return mk(6'h04, 3);
      32'h190: return mk(6'h11, 0);
      32'h198: return mk(6'h00, 26);
      32'h20c: return mk(6'h00, 0);
      32'h80c: return mk(6'h00, 0);
      32'h510: return mk(6'h00, -260);
      32'h514: return mk(6'h12, 0);
      default: return {6'h15, a[27:2]};
    endcase
  endfunction

  function automatic logic [31:0] rnd();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng >> 8;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit in_reset);
    logic [31:0] w;
    logic [5:0] op;
    int off;
    bit acc, ended;
    // stimulus
    stall = (rnd() % 7) == 0;
    flag  = rnd() % 2;
    ack   = 0;
    flush = 0; tick = 0; ext = 0;
    if (!in_reset) begin
      if (m_st == 2 && idle >= 4) begin flush = 1; fpc = 32'h200; end
      else if ((rnd() % 97) == 0) begin flush = 1; fpc = FV; end
      if (m_st == 3 && idle >= 5) begin
        case (sleeps % 3)
          0: ext = 1;
          1: tick = 1;
          default: begin tick = 1; ext = 1; end
        endcase
      end else if (m_st != 3 && (rnd() % 23) == 0) begin
        tick = rnd() % 2; ext = ~tick;   // stray wake while awake: no effect (R8)
      end
    end
    #1;
    dat = prog(adr);
    ack = stb && ((rnd() % 4) != 0);
    #1;
    if (in_reset) begin
      chk(cyc == 0 && valid == 0, "R1", "reset outputs", {cyc, valid}, 0);
      return;
    end
    // bus compare
    chk(cyc == (m_st == 1), (m_st == 3) ? "R7" : (m_st == 2) ? "R6" : "R4", "cyc", cyc, m_st == 1);
    chk(stb == (m_st == 1 && !stall), "R9", "stb", stb, m_st == 1 && !stall);
    if (stb) begin
      chk(adr == m_pc, "R5", "address", adr, m_pc);
      chk(bte == 2'b00, "R2", "bte", bte, 0);
      chk(cti == ((m_beat == BL - 1) ? 3'b111 : 3'b010), "R2", "cti", cti, m_beat);
    end
    // decode-side compare
    chk(valid == e_valid, "R11", "valid", valid, e_valid);
    if (e_valid) begin
      chk(pc == e_pc, "R11", "pc_o", pc, e_pc);
      chk(insn == e_insn, "R2", "insn_o", insn, e_insn);
    end
    // model update
    acc = ack && (m_st == 1) && !stall && !flush;
    if (flush) e_valid = 0;
    else if (acc) begin e_valid = 1; e_pc = m_pc; e_insn = prog(m_pc); delivered++; end
    else if (!stall) e_valid = 0;
    idle++;
    if (flush) begin m_st = 0; m_pc = fpc; idle = 0; end
    else case (m_st)
      0: begin m_st = 1; m_beat = 0; end
      1: if (acc) begin
        w = prog(m_pc); op = w[31:26]; off = {{6{w[25]}}, w[25:0]};
        ended = 1;
        if (op == 6'h00 && off == 0) begin m_st = 3; idle = 0; sleeps++; end
        else if (op == 6'h00) begin m_st = 0; m_pc = m_pc + off * 4; end
        else if (op == 6'h03) begin m_st = 0; m_pc = flag ? m_pc + off * 4 : m_pc + 4; end
        else if (op == 6'h04) begin m_st = 0; m_pc = !flag ? m_pc + off * 4 : m_pc + 4; end
        else if (op == 6'h11 || op == 6'h12) begin m_st = 2; idle = 0; end
        else ended = 0;
        if (ended && m_beat == BL - 1) lastbr++;   // R12 coverage
        if (!ended) begin
          m_pc = m_pc + 4;
          if (m_beat == BL - 1) m_st = 0; else m_beat++;
        end
      end
      3: if (tick) begin m_st = 0; m_pc = TV; end
         else if (ext) begin m_st = 0; m_pc = EV; end
      default: ;
    endcase
    if (acc || m_st >= 2) stuck = 0; else stuck++;
    if (stuck > 200) begin
      chk(0, "R2", "no progress", 0, 1);
      stuck = 0;
    end
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin step(1); @(negedge clk); end
    rst_n = 1;
    for (int i = 0; i < 6000; i++) begin
      step(0);
      @(posedge clk);
      @(negedge clk);
    end
    chk(lastbr > 0, "R12", "branch on last beat seen", lastbr, 1);
    chk(sleeps >= 3, "R8", "sleep/wake rounds", sleeps, 3);
    chk(delivered > 1000, "R2", "delivered words", delivered, 1000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule